// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer (Host Side)

This block is the host-side master for a serial sampling analog-to-digital converter. A single start pulse carries the conversion settings: a channel number, a single-ended or differential choice, a resolution request and two power-down bits. The block then runs one whole conversion as a fixed frame of three bytes, which is 24 serial clock cycles. It drops chip select, builds the control byte and shifts it out, and derives the serial clock from the system clock with a divider. It also captures the converter's data line on every rising edge.

The converter returns its answer across the second and third bytes, so the result does not sit on a byte boundary. The block removes the busy slot and the trailing fill bits. It presents the result right-aligned on a 12-bit port, with a one-cycle done pulse. A converter strapped for 12 bits always returns 12 bits. The host is told about that strap through an input, so it knows which width to extract.

Top module: `sar_readout_ctrl`

## Requirements
- R1: The control byte is sent MSB first on rising serial edges 1 to 8. Its bit 7 is always 1, bits 6..4 are the channel, bit 3 is the 8-bit request, bit 2 is 1 for single-ended, and bits 1..0 are the power-down bits.
- R2: Each accepted start produces exactly 24 rising serial clock edges.
- R3: Chip select goes low 2*HALF_DIV system cycles before the first rising serial edge. The serial clock is high only while chip select is low.
- R4: Every high phase and every low phase of the serial clock inside a frame lasts HALF_DIV system cycles.
- R5: The data line to the converter is low from the falling edge after rising edge 8 until the end of the frame.
- R6: In 12-bit operation the result holds the bits sampled on rising edges 10 through 21, the first of them in result bit 11. Values on edges 1 to 9 and 22 to 24 have no effect.
- R7: When mode_pin_hi and want_8bit are both 1 at start, result[7:0] holds the bits sampled on edges 10 through 17, MSB first, and result[11:8] is 0. In every other case the conversion is 12-bit (R6).
- R8: Chip select rises on the falling edge that follows rising edge 24. done is high for exactly one system cycle, starting one cycle after chip select rises. result is valid during that cycle and holds its value until the next done.
- R9: start is ignored while busy is high, including the cycle in which done is high. No new frame begins and the control byte of the running frame is unchanged.
- R10: After reset, adc_cs_n is 1, adc_dclk, adc_din, busy and done are 0, and result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion (taken only when idle) |
| chan | input | 3 | Channel number for the control byte |
| single_end | input | 1 | 1 selects single-ended input, 0 differential |
| want_8bit | input | 1 | Requests an 8-bit conversion |
| pd_sel | input | 2 | Power-down bits for the control byte |
| mode_pin_hi | input | 1 | 1 when the converter is strapped to allow 8-bit conversions |
| adc_dout | input | 1 | Serial data from the converter |
| adc_dclk | output | 1 | Divided serial clock |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_din | output | 1 | Serial data to the converter |
| busy | output | 1 | High from an accepted start to the end of the done cycle |
| done | output | 1 | One-cycle pulse when result is valid |
| result | output | 12 | Right-aligned conversion result |

## Verification
Two things can fall in the same cycle: the done pulse that ends a frame, and a new start request from a host that is reacting to that done. The bench raises start in the exact cycle it sees done. It then watches the chip select and busy ports for several cycles, and the block passes only if no second frame appears and the finished result is intact. A second case raises start in the middle of a frame. There the bench judges the control byte that its converter model reads, and the number of rising edges it counts.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  localparam int CTRL_BITS   = 8;
  localparam int FRAME_BYTES = 3;
  localparam int FRAME_EDGES = FRAME_BYTES * CTRL_BITS;
  localparam int RES_BITS    = 12;
  localparam int NARROW_BITS = 8;
  localparam int CH_BITS     = 3;
  localparam int PD_BITS     = 2;
  localparam int EDGE_W      = $clog2(FRAME_EDGES + 1);
  // first data bit follows the control byte and one busy slot
  localparam int DATA_TOP    = FRAME_EDGES - CTRL_BITS - 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_CLK, ST_REL, ST_DONE
  } seq_state_t;

  function automatic logic [CTRL_BITS-1:0] make_ctrl(
    input logic [CH_BITS-1:0] ch,
    input logic               narrow,
    input logic               single,
    input logic [PD_BITS-1:0] pd
  );
    return {1'b1, ch, narrow, single, pd};
  endfunction

  // bit presented to the converter for rising edge e (1-based)
  function automatic logic ctrl_bit_for_edge(
    input logic [CTRL_BITS-1:0] c,
    input logic [EDGE_W-1:0]    e
  );
    logic [CTRL_BITS-1:0] s;
    s = c << (e - EDGE_W'(1));
    if (e != '0 && e <= EDGE_W'(CTRL_BITS)) return s[CTRL_BITS-1];
    return 1'b0;
  endfunction

  // rx[FRAME_EDGES-k] holds the bit sampled on rising edge k
  function automatic logic [RES_BITS-1:0] pick_result(
    input logic [FRAME_EDGES-1:0] rx,
    input logic                   narrow
  );
    if (narrow)
      return {{(RES_BITS-NARROW_BITS){1'b0}}, rx[DATA_TOP -: NARROW_BITS]};
    return rx[DATA_TOP -: RES_BITS];
  endfunction
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + CW'(1);
  end

  generate
    if (HALF_DIV > 1) begin : g_spacing
      assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/sar_frame_seq.sv
module sar_frame_seq
  import sar_rd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CTRL_BITS-1:0] ctrl_in,
  input  logic                 tick,
  output logic                 run,
  output logic                 accept,
  output logic                 rise_evt,
  output logic                 load_evt,
  output logic                 dclk,
  output logic                 cs_n,
  output logic                 din,
  output logic                 busy,
  output logic                 done
);
  seq_state_t           state;
  logic [EDGE_W-1:0]    edge_cnt;
  logic                 lead_half;
  logic [CTRL_BITS-1:0] ctrl_q;
  logic                 fall_evt;

  assign run      = (state == ST_LEAD) || (state == ST_CLK);
  assign accept   = start && (state == ST_IDLE);
  assign rise_evt = tick && (((state == ST_LEAD) && lead_half) ||
                             ((state == ST_CLK) && !dclk));
  assign fall_evt = tick && (state == ST_CLK) && dclk;
  assign load_evt = fall_evt && (edge_cnt == EDGE_W'(FRAME_EDGES));
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      edge_cnt  <= '0;
      lead_half <= 1'b0;
      ctrl_q    <= '0;
      dclk      <= 1'b0;
      cs_n      <= 1'b1;
      din       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          ctrl_q    <= ctrl_in;
          cs_n      <= 1'b0;
          din       <= ctrl_in[CTRL_BITS-1];
          edge_cnt  <= '0;
          lead_half <= 1'b0;
          state     <= ST_LEAD;
        end
        ST_LEAD: if (tick) begin
          if (lead_half) begin
            dclk     <= 1'b1;
            edge_cnt <= EDGE_W'(1);
            state    <= ST_CLK;
          end else begin
            lead_half <= 1'b1;
          end
        end
        ST_CLK: if (tick) begin
          if (dclk) begin
            dclk <= 1'b0;
            if (edge_cnt == EDGE_W'(FRAME_EDGES)) begin
              cs_n  <= 1'b1;
              din   <= 1'b0;
              state <= ST_REL;
            end else begin
              din <= ctrl_bit_for_edge(ctrl_q, edge_cnt + EDGE_W'(1));
            end
          end else begin
            dclk     <= 1'b1;
            edge_cnt <= edge_cnt + EDGE_W'(1);
          end
        end
        ST_REL:  state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_clk_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |-> !cs_n);
  assert_edge_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= EDGE_W'(FRAME_EDGES));
  assert_din_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !dclk && edge_cnt >= EDGE_W'(CTRL_BITS)) |-> !din);
  assert_done_after_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> done);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> ($stable(ctrl_q) && !$fell(cs_n)));
endmodule

// File: rtl/sar_rx_shift.sv
module sar_rx_shift
  import sar_rd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_en,
  input  logic                   bit_in,
  output logic [FRAME_EDGES-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data <= '0;
    else if (shift_en) data <= {data[FRAME_EDGES-2:0], bit_in};
  end
endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
  import sar_rd_pkg::*;
#(
  parameter int HALF_DIV = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CH_BITS-1:0]  chan,
  input  logic                single_end,
  input  logic                want_8bit,
  input  logic [PD_BITS-1:0]  pd_sel,
  input  logic                mode_pin_hi,
  input  logic                adc_dout,
  output logic                adc_dclk,
  output logic                adc_cs_n,
  output logic                adc_din,
  output logic                busy,
  output logic                done,
  output logic [RES_BITS-1:0] result
);
  logic                   run, tick, accept, rise_evt, load_evt;
  logic                   narrow_q;
  logic [CTRL_BITS-1:0]   ctrl_word;
  logic [FRAME_EDGES-1:0] rx_bits;

  assign ctrl_word = make_ctrl(chan, want_8bit, single_end, pd_sel);

  sar_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  sar_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_in(ctrl_word),
    .tick(tick), .run(run), .accept(accept), .rise_evt(rise_evt),
    .load_evt(load_evt), .dclk(adc_dclk), .cs_n(adc_cs_n),
    .din(adc_din), .busy(busy), .done(done)
  );

  sar_rx_shift u_rx (
    .clk(clk), .rst_n(rst_n), .shift_en(rise_evt), .bit_in(adc_dout),
    .data(rx_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      narrow_q <= 1'b0;
      result   <= '0;
    end else begin
      if (accept)   narrow_q <= mode_pin_hi && want_8bit;
      if (load_evt) result   <= pick_result(rx_bits, narrow_q);
    end
  end

  assert_narrow_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && narrow_q) |-> (result[RES_BITS-1:NARROW_BITS] == '0));
  assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> $stable(result));
endmodule

// File: tb/tb_sar_readout_ctrl.sv
module tb_sar_readout_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] chan = '0;
  logic single_end = 1'b0, want_8bit = 1'b0, mode_pin_hi = 1'b0;
  logic [1:0] pd_sel = '0;
  logic adc_dout = 1'b0;
  logic adc_dclk, adc_cs_n, adc_din, busy, done;
  logic [11:0] result;

  sar_readout_ctrl #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan),
    .single_end(single_end), .want_8bit(want_8bit), .pd_sel(pd_sel),
    .mode_pin_hi(mode_pin_hi), .adc_dout(adc_dout), .adc_dclk(adc_dclk),
    .adc_cs_n(adc_cs_n), .adc_din(adc_din), .busy(busy), .done(done),
    .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc++;

  // converter model
  logic [23:0] tx_frame = '0;
  logic [7:0]  m_ctrl = '0;
  int m_rise = 0, m_din_hi = 0, m_phase_bad = 0;
  int t_cs = 0, t_first = 0, t_csr = 0, t_done = 0, t_hi = 0, t_lo = 0;

  always @(posedge adc_dclk) begin
    if (m_rise == 0) t_first = cyc;
    else if (cyc - t_lo != HALF) m_phase_bad++;
    if (adc_cs_n) m_phase_bad++;
    t_hi = cyc;
    if (m_rise < 8) m_ctrl = {m_ctrl[6:0], adc_din};
    else if (adc_din) m_din_hi++;
    m_rise++;
  end
  always @(negedge adc_dclk) begin
    if (m_rise > 0) begin
      t_lo = cyc;
      if (cyc - t_hi != HALF) m_phase_bad++;
      adc_dout = (m_rise < 24) ? tx_frame[23 - m_rise] : 1'b0;
    end
  end
  always @(negedge adc_cs_n) t_cs = cyc;
  always @(posedge adc_cs_n) t_csr = cyc;
  always @(posedge done) t_done = cyc;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // poke: 0 none, 1 start mid-frame, 2 start in the done cycle
  task automatic run_conv(input logic [2:0] ch, input logic sgl, input logic [1:0] pd,
                          input logic w8, input logic pin, input logic [11:0] data,
                          input int poke);
    logic narrow;
    logic [11:0] exp_res;
    logic [7:0] exp_ctrl;
    int w, stray;
    narrow   = w8 && pin;
    exp_res  = narrow ? {4'h0, data[7:0]} : data;
    exp_ctrl = {1'b1, ch, w8, sgl, pd};
    tx_frame = narrow ? {8'hA5, 1'b1, data[7:0], 7'b1011011}
                      : {8'h5A, 1'b1, data, 3'b111};
    m_rise = 0; m_ctrl = '0; m_din_hi = 0; m_phase_bad = 0;
    adc_dout = tx_frame[23];
    @(negedge clk);
    chan = ch; single_end = sgl; pd_sel = pd; want_8bit = w8; mode_pin_hi = pin;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke == 1) begin
      repeat (20) @(negedge clk);
      chan = ~ch; want_8bit = ~w8; start = 1'b1;
      @(negedge clk);
      start = 1'b0; chan = ch; want_8bit = w8;
    end
    w = 0;
    while (!done && w < 2000) begin @(negedge clk); w++; end
    chk("R8", "done seen", int'(done), 1);
    chk(narrow ? "R7" : "R6", "result", int'(result), int'(exp_res));
    chk("R1", "control byte", int'(m_ctrl), int'(exp_ctrl));
    chk("R2", "rising edges", m_rise, 24);
    chk("R5", "din high after control byte", m_din_hi, 0);
    chk("R3", "cs lead cycles", t_first - t_cs, 2*HALF);
    chk("R4", "phase errors", m_phase_bad, 0);
    chk("R8", "cs rise to done", t_done - t_csr, 1);
    if (poke == 2) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8", "done width", int'(done), 0);
    chk("R8", "result held", int'(result), int'(exp_res));
    if (poke != 0) begin
      stray = 0;
      repeat (10) begin
        @(negedge clk);
        if (busy || !adc_cs_n) stray++;
      end
      chk("R9", "frame after ignored start", stray, 0);
      chk("R9", "edges after ignored start", m_rise, 24);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "cs_n", int'(adc_cs_n), 1);
    chk("R10", "dclk", int'(adc_dclk), 0);
    chk("R10", "din", int'(adc_din), 0);
    chk("R10", "busy", int'(busy), 0);
    chk("R10", "done", int'(done), 0);
    chk("R10", "result", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_twelve();
    run_conv(3'd5, 1'b1, 2'b11, 1'b0, 1'b0, 12'hA5C, 0);  // R6
    run_conv(3'd0, 1'b0, 2'b00, 1'b0, 1'b1, 12'h001, 0);  // R6
    run_conv(3'd7, 1'b1, 2'b10, 1'b0, 1'b0, 12'hFFF, 0);  // R6
    run_conv(3'd2, 1'b0, 2'b01, 1'b1, 1'b0, 12'h800, 0);  // R7 pin low keeps 12 bits
  endtask

  task automatic t_eight();
    run_conv(3'd4, 1'b1, 2'b01, 1'b1, 1'b1, 12'h03C, 0);  // R7
    run_conv(3'd1, 1'b0, 2'b11, 1'b1, 1'b1, 12'h0FF, 0);  // R7
  endtask

  task automatic t_start_busy();
    run_conv(3'd6, 1'b1, 2'b00, 1'b0, 1'b1, 12'h3C5, 1);  // R9 mid-frame
  endtask

  task automatic t_start_on_done();
    run_conv(3'd3, 1'b0, 2'b10, 1'b0, 1'b0, 12'h6B2, 2);  // R9 with done
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_twelve();
    t_eight();
    t_start_busy();
    t_start_on_done();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule